// File: doc/BRIEF.md
# Parity-Framed Four-Channel Sample Serializer

This block takes one 8-bit reading from each of four converter channels per frame. It adds an odd-parity bit to each reading and sends the resulting 36 bits over three serial data lanes. The frame is twelve bit-slots long. Channels A, B and C each own one lane for the first nine slots: eight data bits, least significant first, then the parity bit. Channel D's nine bits are shared out three per lane across the last three slots. Frames follow one another without gaps for as long as reset is low. At a 24 MHz bit clock this gives each channel 2 million samples per second.

A fourth output forwards the bit clock, inverted, so that a receiver can sample each lane on the rising edge of that clock, in the middle of each slot. A one-cycle strobe marks the cycle in which slot 0 is on the lanes. All four readings are captured on one clock edge just before each frame starts, so input changes at any other time cannot disturb a frame that is being sent.

Top module: `par_lane_serializer`

## Requirements
- R1: While `rst` is high at a rising edge, `lane_q` and `frame_start` become 0 and `clk_fwd` stays low. After `rst` falls, the first rising edge captures the inputs. The second rising edge raises `frame_start` and puts slot 0 of that captured frame on the lanes.
- R2: The parity bit of each channel is 1 when its 8-bit reading has an even number of ones and 0 otherwise, so the nine bits always hold an odd number of ones.
- R3: In slots 0 to 7, `lane_q[0]`, `lane_q[1]` and `lane_q[2]` carry bit k of channels A, B and C, where k is the slot number.
- R4: In slot 8, `lane_q[0]`, `lane_q[1]` and `lane_q[2]` carry the parity bits of A, B and C.
- R5: In slots 9, 10 and 11, `lane_q[0]` carries D bits 0, 1, 2; `lane_q[1]` carries D bits 3, 4, 5; and `lane_q[2]` carries D bits 6, 7 and then D's parity.
- R6: `frame_start` is high for exactly one cycle per frame, in the cycle in which slot 0 is on the lanes. Consecutive pulses are 12 cycles apart.
- R7: The inputs are captured only on the rising edge at which the lanes move to slot 11 of the current frame, and that capture is sent in the next frame. Input values present at any other edge have no effect on the lanes.
- R8: Once running, frames repeat back to back. The internal slot index steps 0, 1, ..., 11, 0 with no idle cycles and no handshake.
- R9: After the first rising edge with `rst` low, `clk_fwd` equals the inverted bit clock. It is high while `clk` is low, so its rising edge falls in the middle of each slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_a | input | 8 | Channel A reading |
| smp_b | input | 8 | Channel B reading |
| smp_c | input | 8 | Channel C reading |
| smp_d | input | 8 | Channel D reading |
| lane_q | output | 3 | Registered serial data lanes, bit 0 carries channel A |
| clk_fwd | output | 1 | Forwarded bit clock, inverted, gated off until running |
| frame_start | output | 1 | One-cycle pulse while slot 0 is on the lanes |

## Verification
Each input set is captured on one edge and reaches the lanes as slot 0 one edge later, together with `frame_start`. Slot k of that frame then appears k edges after the `frame_start` edge. The bench therefore aligns on the falling edge where `frame_start` is seen, and compares each lane at each of the next twelve falling edges with a bit computed from the requirement formulas. New inputs are always driven at a falling edge. To test that inputs are ignored outside the capture edge, the inputs are corrupted at slot 0 and restored at slot 10, which is the last falling edge before the capture. The forwarded clock is checked just after a rising edge and at a falling edge, to confirm its inversion.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  // Which part of a frame a slot belongs to
  typedef enum logic [1:0] {
    PH_DATA  = 2'd0,  // own channel data bit
    PH_PAR   = 2'd1,  // own channel parity bit
    PH_SPLIT = 2'd2   // shared fourth-channel bits
  } slot_phase_e;

  function automatic slot_phase_e phase_of(input int unsigned slot,
                                           input int unsigned sample_w);
    if (slot < sample_w)
      return PH_DATA;
    else if (slot == sample_w)
      return PH_PAR;
    else
      return PH_SPLIT;
  endfunction

endpackage

// File: rtl/sfs_slot_counter.sv
module sfs_slot_counter #(
  parameter int SLOTS = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] slot,
  output logic             last
);

  assign last = (slot == CNT_W'(SLOTS - 1));

  // Reset parks on the last slot so the first free edge performs a capture
  always_ff @(posedge clk) begin
    if (rst)
      slot <= CNT_W'(SLOTS - 1);
    else if (last)
      slot <= '0;
    else
      slot <= slot + 1'b1;
  end

endmodule

// File: rtl/sfs_frame_latch.sv
module sfs_frame_latch #(
  parameter int SAMPLE_W = 8,
  parameter int CHANS    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [CHANS*SAMPLE_W-1:0] smp_in,
  output logic [CHANS*SAMPLE_W-1:0] smp_q,
  output logic [CHANS-1:0]          par_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
      par_q <= '0;
    end else if (load) begin
      smp_q <= smp_in;
      for (int c = 0; c < CHANS; c++)
        par_q[c] <= ~^smp_in[c*SAMPLE_W +: SAMPLE_W];  // odd parity
    end
  end

endmodule

// File: rtl/sfs_lane_mux.sv
module sfs_lane_mux #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 3,
  parameter int CNT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CNT_W-1:0]              slot,
  input  logic                          start_in,
  input  logic [(LANES+1)*SAMPLE_W-1:0] smp_q,
  input  logic [LANES:0]                par_q,
  output logic [LANES-1:0]              lane_q,
  output logic                          frame_start_q,
  output logic                          fwd_en_q
);
  import sfs_pkg::*;

  localparam int WORD_W = SAMPLE_W + 1;
  localparam int SPLIT  = WORD_W / LANES;
  localparam int IDX_W  = $clog2(SAMPLE_W);
  localparam int TW_W   = $clog2(WORD_W);

  logic [WORD_W-1:0] tail_word;
  logic [LANES-1:0]  lane_d;

  assign tail_word = {par_q[LANES], smp_q[LANES*SAMPLE_W +: SAMPLE_W]};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SAMPLE_W-1:0] own;
    logic [TW_W-1:0]     tidx;
    logic                bit_d;

    assign own  = smp_q[l*SAMPLE_W +: SAMPLE_W];
    assign tidx = TW_W'(l * SPLIT) + TW_W'(slot - CNT_W'(WORD_W));

    always_comb begin
      case (phase_of(32'(slot), SAMPLE_W))
        PH_DATA:  bit_d = own[slot[IDX_W-1:0]];
        PH_PAR:   bit_d = par_q[l];
        PH_SPLIT: bit_d = tail_word[tidx];
        default:  bit_d = 1'b0;
      endcase
    end

    assign lane_d[l] = bit_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q        <= '0;
      frame_start_q <= 1'b0;
      fwd_en_q      <= 1'b0;
    end else begin
      lane_q        <= lane_d;
      frame_start_q <= start_in;
      fwd_en_q      <= 1'b1;
    end
  end

endmodule

// File: rtl/par_lane_serializer.sv
module par_lane_serializer #(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp_a,
  input  logic [SAMPLE_W-1:0] smp_b,
  input  logic [SAMPLE_W-1:0] smp_c,
  input  logic [SAMPLE_W-1:0] smp_d,
  output logic [2:0]          lane_q,
  output logic                clk_fwd,
  output logic                frame_start
);

  // Three data lanes serve four channels; the fourth is split across them
  localparam int LANES  = 3;
  localparam int CHANS  = LANES + 1;
  localparam int WORD_W = SAMPLE_W + 1;
  localparam int SLOTS  = WORD_W + WORD_W / LANES;
  localparam int CNT_W  = $clog2(SLOTS);

  logic [CNT_W-1:0]          slot_cnt;
  logic                      slot_last;
  logic [CHANS*SAMPLE_W-1:0] smp_bus;
  logic [CHANS*SAMPLE_W-1:0] smp_q;
  logic [CHANS-1:0]          par_q;
  logic                      fwd_en_q;

  assign smp_bus = {smp_d, smp_c, smp_b, smp_a};

  sfs_slot_counter #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .slot (slot_cnt),
    .last (slot_last)
  );

  sfs_frame_latch #(.SAMPLE_W(SAMPLE_W), .CHANS(CHANS)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .load   (slot_last),
    .smp_in (smp_bus),
    .smp_q  (smp_q),
    .par_q  (par_q)
  );

  sfs_lane_mux #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .CNT_W(CNT_W)) u_mux (
    .clk           (clk),
    .rst           (rst),
    .slot          (slot_cnt),
    .start_in      (slot_cnt == '0),
    .smp_q         (smp_q),
    .par_q         (par_q),
    .lane_q        (lane_q),
    .frame_start_q (frame_start),
    .fwd_en_q      (fwd_en_q)
  );

  // Enable changes at the rising edge while the inverted clock is low: no runt
  assign clk_fwd = fwd_en_q & ~clk;

endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int SAMPLE_W = 8,
  parameter int SLOTS    = 12,
  parameter int CNT_W    = 4,
  parameter int CHANS    = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      frame_start,
  input logic [CNT_W-1:0]          slot,
  input logic [CHANS*SAMPLE_W-1:0] smp_q,
  input logic [CHANS-1:0]          par_q
);

  logic       seen;
  logic [7:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (frame_start) begin
      seen <= 1'b1;
      gap  <= '0;
    end else if (gap != 8'hFF) begin
      gap <= gap + 1'b1;
    end
  end

  // R6
  fs_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  // R6
  fs_period_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_start && seen) |-> (gap == 8'(SLOTS - 1)));

  // R6
  fs_align_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ($past(slot) == '0));

  // R8
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    slot < CNT_W'(SLOTS));

  // R8
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (slot != CNT_W'(SLOTS - 1)) |=> (slot == CNT_W'($past(slot) + 1'b1)));

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (slot != CNT_W'(SLOTS - 1)) |=> $stable({smp_q, par_q}));

endmodule

bind par_lane_serializer sfs_checker #(
  .SAMPLE_W (SAMPLE_W),
  .SLOTS    (SLOTS),
  .CNT_W    (CNT_W),
  .CHANS    (CHANS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .slot        (slot_cnt),
  .smp_q       (smp_q),
  .par_q       (par_q)
);

// File: tb/par_lane_serializer_test.sv
module par_lane_serializer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] smp_a = '0, smp_b = '0, smp_c = '0, smp_d = '0;
  logic [2:0] lane_q;
  logic       clk_fwd;
  logic       frame_start;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  par_lane_serializer uut (
    .clk         (clk),
    .rst         (rst),
    .smp_a       (smp_a),
    .smp_b       (smp_b),
    .smp_c       (smp_c),
    .smp_d       (smp_d),
    .lane_q      (lane_q),
    .clk_fwd     (clk_fwd),
    .frame_start (frame_start)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // nine-bit word: data plus a bit that makes the ones count odd
  function automatic logic [8:0] word9(input logic [7:0] v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(v[i]);
    return {((ones % 2) == 0), v};
  endfunction

  function automatic logic exp_bit(input logic [7:0] a, b, c, d,
                                   input int lane, input int slot);
    logic [8:0] w [4];
    w[0] = word9(a); w[1] = word9(b); w[2] = word9(c); w[3] = word9(d);
    if (slot <= 8) return w[lane][slot];
    return w[3][lane*3 + slot - 9];
  endfunction

  task automatic drive(input logic [7:0] a, b, c, d);
    smp_a = a; smp_b = b; smp_c = c; smp_d = d;
  endtask

  // Called at the falling edge showing slot 0; returns at the next one
  task automatic check_frame(input logic [7:0] ea, eb, ec, ed,
                             input logic [7:0] na, nb, nc, nd,
                             input bit glitch, input logic [7:0] gv);
    for (int s = 0; s < 12; s++) begin
      string tag;
      if (s < 8)       tag = "R3 data slot";
      else if (s == 8) tag = "R2/R4 parity slot";
      else             tag = "R5 split slot";
      chk(frame_start == (s == 0), "R6 frame_start", 32'(frame_start), 32'(s == 0));
      for (int l = 0; l < 3; l++) begin
        logic e;
        e = exp_bit(ea, eb, ec, ed, l, s);
        chk(lane_q[l] === e, $sformatf("%s %0d lane %0d", tag, s, l),
            32'(lane_q[l]), 32'(e));
      end
      if (s == 0) begin
        if (glitch) drive(gv, gv, gv, gv);
        else        drive(na, nb, nc, nd);
      end
      if (s == 10) drive(na, nb, nc, nd);
      @(negedge clk);
    end
  endtask

  task automatic t_reset_start();
    drive(8'h00, 8'hFF, 8'h01, 8'hB2);
    repeat (4) @(negedge clk);
    chk(lane_q == 3'b000, "R1 lanes in reset", 32'(lane_q), 0);
    chk(frame_start == 1'b0, "R1 strobe in reset", 32'(frame_start), 0);
    chk(clk_fwd == 1'b0, "R1 clk_fwd in reset", 32'(clk_fwd), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(frame_start == 1'b0, "R1 no strobe after first edge", 32'(frame_start), 0);
    @(negedge clk);
    chk(frame_start == 1'b1, "R1 strobe after second edge", 32'(frame_start), 1);
  endtask

  task automatic t_patterns();
    check_frame(8'h00, 8'hFF, 8'h01, 8'hB2, 8'hA5, 8'h3C, 8'h80, 8'h7F, 1'b0, 8'h00);
    check_frame(8'hA5, 8'h3C, 8'h80, 8'h7F, 8'h5E, 8'hC3, 8'hEE, 8'h01, 1'b0, 8'h00);
  endtask

  task automatic t_capture_window();
    // R7: inputs corrupted from slot 0 to slot 10 must not show up
    check_frame(8'h5E, 8'hC3, 8'hEE, 8'h01, 8'h96, 8'h0F, 8'h69, 8'hFF, 1'b1, 8'h00);
    check_frame(8'h96, 8'h0F, 8'h69, 8'hFF, 8'h12, 8'h34, 8'h56, 8'h78, 1'b1, 8'hFF);
    check_frame(8'h12, 8'h34, 8'h56, 8'h78, 8'h12, 8'h34, 8'h56, 8'h78, 1'b0, 8'h00);
  endtask

  task automatic t_mid_reset();
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(lane_q == 3'b000, "R1 lanes after mid-frame reset", 32'(lane_q), 0);
    chk(frame_start == 1'b0, "R1 strobe after mid-frame reset", 32'(frame_start), 0);
    chk(clk_fwd == 1'b0, "R1 clk_fwd after mid-frame reset", 32'(clk_fwd), 0);
    drive(8'hC9, 8'h70, 8'h0E, 8'h6D);
    rst = 1'b0;
    @(negedge clk);
    chk(frame_start == 1'b0, "R1 restart first edge", 32'(frame_start), 0);
    @(negedge clk);
    check_frame(8'hC9, 8'h70, 8'h0E, 8'h6D, 8'h55, 8'hAA, 8'h33, 8'hCC, 1'b0, 8'h00);
    check_frame(8'h55, 8'hAA, 8'h33, 8'hCC, 8'h55, 8'hAA, 8'h33, 8'hCC, 1'b0, 8'h00);
  endtask

  task automatic t_clk_fwd();
    chk(clk_fwd == 1'b1, "R9 clk_fwd high while clk low", 32'(clk_fwd), 1);
    @(posedge clk);
    #1;
    chk(clk_fwd == 1'b0, "R9 clk_fwd low while clk high", 32'(clk_fwd), 0);
    @(negedge clk);
  endtask

  initial begin
    t_reset_start();
    t_patterns();
    t_capture_window();
    t_mid_reset();
    t_clk_fwd();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule